// File: doc/BRIEF.md
# Pipelined Quadtree Range Search

This block finds the primitive range that holds one header field value. It is the per-field search stage of a multi-field packet classifier. The right endpoints of all primitive ranges sit in a balanced quadtree. Each internal node keeps three sorted endpoints and has four children. Each tree level has its own memory and is read by its own pipeline stage, so a new lookup can enter on every clock. No child pointers are stored. The address of a child is the parent's address shifted left by two bits, with the 2-bit comparison outcome in the low bits. After the last level, the leaf address indexes a result memory. Each result entry holds a range identifier and a fixed number of {table ID, index} tuples, one for each subset the range belongs to.

Two lookup ports, A and B, run side by side and read the same stored tree and result table. This gives two independent lookups per clock. The tree and the result table are cleared at reset: every endpoint is set to the field's maximum and every result entry is set to zero. They are then filled through a simple load port. Building the tree is left to the software that drives that port.

Top module: `qt_range_search`

## Requirements
- R1: Right after reset, both output valid flags are low. Every endpoint reads as the all-ones key value, so any key is steered to leaf 0. Every result entry reads as zero.
- R2: At every level, the stage counts how many of the node's three endpoints are strictly less than the key. That count (0 to 3) picks the child, and it is appended as the low two bits of the address. A key equal to an endpoint therefore lands in the range whose right endpoint it equals. With sorted endpoints e0..e14 loaded as a full two-level tree, the leaf equals the number of endpoints below the key.
- R3: Endpoint slots set to the all-ones value never divert the search. A tree holding fewer than 16 ranges, padded with all-ones slots, returns the correct leaf for every key, including the all-ones key.
- R4: A valid lookup presented at a clock edge has its result on the outputs after LEVELS+1 edges, counting the edge that samples it. The result is the range ID in bits [3:0] of the selected result entry and the tuples in bits [19:4].
- R5: Each port accepts a new lookup on every clock, with no stall and no gap between results.
- R6: Ports A and B act independently on different keys. Equal keys entered together on both ports give identical results.
- R7: An input with its valid flag low gives an output with its valid flag low, LEVELS+1 edges later. Valid and invalid inputs keep their order.
- R8: The load port writes when loadEn is high.
  - loadSel equal to a tree level below LEVELS writes that level's node at loadAddr. Slot 0 is in data bits [7:0], slot 1 in [15:8] and slot 2 in [23:16]. The root lives at address 0.
  - loadSel equal to LEVELS writes the result entry at loadAddr. The range ID is in bits [3:0]. Tuple k is in bits [4+8k +: 8], with the index in the low 6 bits and the table ID in the high 2 bits.
  - The new contents steer every later lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Write strobe of the load port |
| loadSel | input | SEL_W (2) | Memory select: tree level 0..LEVELS-1, or LEVELS for the result table |
| loadAddr | input | ADDR_W (4) | Node or result entry address |
| loadData | input | LD_W (24) | Node endpoints or result entry |
| keyA | input | KEY_W (8) | Field value, port A |
| inValidA | input | 1 | Lookup valid, port A |
| keyB | input | KEY_W (8) | Field value, port B |
| inValidB | input | 1 | Lookup valid, port B |
| outValidA | output | 1 | Result valid, port A |
| rangeA | output | RID_W (4) | Range ID, port A |
| tuplesA | output | TUPLES*TUP_W (16) | {table ID, index} tuples, port A |
| outValidB | output | 1 | Result valid, port B |
| rangeB | output | RID_W (4) | Range ID, port B |
| tuplesB | output | TUPLES*TUP_W (16) | {table ID, index} tuples, port B |

## Verification
The port-agreement property does not depend on whether loads and lookups overlap. Two lookups with equal keys move through the stages in lockstep and read each memory in the same cycle, so they must agree either way. The valid-timing properties take nothing for granted about the keys. The bench model assumes the endpoints it loads are sorted, so that a count over the flat endpoint list equals the tree's leaf. The stimulus loads sorted lists only, and drains the pipeline with idle cycles before every load, so no lookup is in flight while the memories change.

// File: rtl/qt_pkg.sv
package qt_pkg;
  localparam int MAX_LEVELS = 8;

  // write strobes from control to datapath
  typedef struct packed {
    logic [MAX_LEVELS-1:0] treeWe;
    logic                  resWe;
  } qt_strobe_t;
endpackage

// File: rtl/qt_ctrl.sv
module qt_ctrl
  import qt_pkg::*;
#(
  parameter int LEVELS = 2,
  parameter int SEL_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loadEn,
  input  logic [SEL_W-1:0] loadSel,
  input  logic             inValidA,
  input  logic             inValidB,
  output qt_strobe_t       stb,
  output logic             outValidA,
  output logic             outValidB
);
  localparam int LAT = LEVELS + 1;

  logic [LAT-1:0] vPipeA, vPipeB;

  always_comb begin
    stb = '0;
    if (loadEn) begin
      if (int'(loadSel) < LEVELS) stb.treeWe[loadSel] = 1'b1;
      else if (int'(loadSel) == LEVELS) stb.resWe = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vPipeA <= '0;
      vPipeB <= '0;
    end else begin
      vPipeA <= {vPipeA[LAT-2:0], inValidA};
      vPipeB <= {vPipeB[LAT-2:0], inValidB};
    end
  end

  assign outValidA = vPipeA[LAT-1];
  assign outValidB = vPipeB[LAT-1];
endmodule

// File: rtl/qt_datapath.sv
module qt_datapath
  import qt_pkg::*;
#(
  parameter int KEY_W  = 8,
  parameter int LEVELS = 2,
  parameter int RES_W  = 20,
  parameter int LD_W   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  qt_strobe_t        stb,
  input  logic [2*LEVELS-1:0] loadAddr,
  input  logic [LD_W-1:0]   loadData,
  input  logic [KEY_W-1:0]  keyA,
  input  logic [KEY_W-1:0]  keyB,
  output logic [RES_W-1:0]  resA,
  output logic [RES_W-1:0]  resB
);
  localparam int ADDR_W = 2 * LEVELS;
  localparam int NODE_W = 3 * KEY_W;

  for (genvar l = 0; l < LEVELS; l++) begin : gLvl
    localparam int NI_W  = (l == 0) ? 1 : 2 * l;
    localparam int NODES = 1 << NI_W;

    logic [NODE_W-1:0] mem [NODES];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int n = 0; n < NODES; n++) mem[n] <= '1;
      end else if (stb.treeWe[l]) begin
        mem[loadAddr[NI_W-1:0]] <= loadData[NODE_W-1:0];
      end
    end

    for (genvar p = 0; p < 2; p++) begin : gPort
      logic [KEY_W-1:0]  sKey, qKey;
      logic [ADDR_W-1:0] sAddr, qAddr;
      logic [NODE_W-1:0] node;
      logic [1:0]        digit;

      if (l == 0) begin : gSrc
        assign sKey  = (p == 0) ? keyA : keyB;
        assign sAddr = '0;
      end else begin : gSrc
        assign sKey  = gLvl[l-1].gPort[p].qKey;
        assign sAddr = gLvl[l-1].gPort[p].qAddr;
      end

      always_comb begin
        node  = mem[sAddr[NI_W-1:0]];
        digit = '0;
        for (int s = 0; s < 3; s++)
          if (node[s*KEY_W +: KEY_W] < sKey) digit = digit + 2'd1;
      end

      always_ff @(posedge clk) begin
        qKey  <= sKey;
        qAddr <= (sAddr << 2) | ADDR_W'(digit);
      end
    end
  end

  logic [RES_W-1:0] resMem [1 << ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < (1 << ADDR_W); n++) resMem[n] <= '0;
    end else if (stb.resWe) begin
      resMem[loadAddr] <= loadData[RES_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    resA <= resMem[gLvl[LEVELS-1].gPort[0].qAddr];
    resB <= resMem[gLvl[LEVELS-1].gPort[1].qAddr];
  end
endmodule

// File: rtl/qt_range_search.sv
module qt_range_search
  import qt_pkg::*;
#(
  parameter int KEY_W  = 8,
  parameter int LEVELS = 2,
  parameter int TUPLES = 2,
  parameter int TID_W  = 2,
  parameter int IDX_W  = 6,
  localparam int ADDR_W = 2 * LEVELS,
  localparam int RID_W  = ADDR_W,
  localparam int TUP_W  = TID_W + IDX_W,
  localparam int RES_W  = RID_W + TUPLES * TUP_W,
  localparam int NODE_W = 3 * KEY_W,
  localparam int LD_W   = (NODE_W > RES_W) ? NODE_W : RES_W,
  localparam int SEL_W  = $clog2(LEVELS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    loadEn,
  input  logic [SEL_W-1:0]        loadSel,
  input  logic [ADDR_W-1:0]       loadAddr,
  input  logic [LD_W-1:0]         loadData,
  input  logic [KEY_W-1:0]        keyA,
  input  logic                    inValidA,
  input  logic [KEY_W-1:0]        keyB,
  input  logic                    inValidB,
  output logic                    outValidA,
  output logic [RID_W-1:0]        rangeA,
  output logic [TUPLES*TUP_W-1:0] tuplesA,
  output logic                    outValidB,
  output logic [RID_W-1:0]        rangeB,
  output logic [TUPLES*TUP_W-1:0] tuplesB
);
  qt_strobe_t       stb;
  logic [RES_W-1:0] resA, resB;

  qt_ctrl #(.LEVELS(LEVELS), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .loadEn(loadEn), .loadSel(loadSel),
    .inValidA(inValidA), .inValidB(inValidB), .stb(stb),
    .outValidA(outValidA), .outValidB(outValidB)
  );

  qt_datapath #(.KEY_W(KEY_W), .LEVELS(LEVELS), .RES_W(RES_W), .LD_W(LD_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .loadAddr(loadAddr), .loadData(loadData),
    .keyA(keyA), .keyB(keyB), .resA(resA), .resB(resB)
  );

  assign rangeA  = resA[RID_W-1:0];
  assign tuplesA = resA[RES_W-1:RID_W];
  assign rangeB  = resB[RID_W-1:0];
  assign tuplesB = resB[RES_W-1:RID_W];
endmodule

// File: rtl/qt_range_search_chk.sv
module qt_range_search_chk #(
  parameter int KEY_W  = 8,
  parameter int LEVELS = 2,
  parameter int RID_W  = 4,
  parameter int TPL_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [KEY_W-1:0] keyA,
  input logic             inValidA,
  input logic [KEY_W-1:0] keyB,
  input logic             inValidB,
  input logic             outValidA,
  input logic [RID_W-1:0] rangeA,
  input logic [TPL_W-1:0] tuplesA,
  input logic             outValidB,
  input logic [RID_W-1:0] rangeB,
  input logic [TPL_W-1:0] tuplesB
);
  localparam int LAT = LEVELS + 1;

  logic [LAT-1:0] seenA, seenB, twin;
  logic           firstCyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seenA    <= '0;
      seenB    <= '0;
      twin     <= '0;
      firstCyc <= 1'b1;
    end else begin
      seenA    <= {seenA[LAT-2:0], inValidA};
      seenB    <= {seenB[LAT-2:0], inValidB};
      twin     <= {twin[LAT-2:0], inValidA && inValidB && (keyA == keyB)};
      firstCyc <= 1'b0;
    end
  end

  // R1
  r1_idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    firstCyc |-> (!outValidA && !outValidB));

  // R4
  r4_latency_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValidA == seenA[LAT-1]);

  // R7
  r7_latency_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValidB == seenB[LAT-1]);

  // R6
  r6_port_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    twin[LAT-1] |-> (outValidA && outValidB && rangeA == rangeB && tuplesA == tuplesB));
endmodule

bind qt_range_search qt_range_search_chk #(
  .KEY_W(KEY_W), .LEVELS(LEVELS), .RID_W(RID_W), .TPL_W(TUPLES*TUP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .keyA(keyA), .inValidA(inValidA), .keyB(keyB),
  .inValidB(inValidB), .outValidA(outValidA), .rangeA(rangeA), .tuplesA(tuplesA),
  .outValidB(outValidB), .rangeB(rangeB), .tuplesB(tuplesB)
);

// File: tb/sim_qt_range_search.sv
module sim_qt_range_search;
  localparam int CLK_P = 10;
  localparam int LAT   = 3;

  typedef struct {
    bit          v;
    logic [3:0]  rid;
    logic [15:0] tup;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        loadEn = 1'b0;
  logic [1:0]  loadSel = '0;
  logic [3:0]  loadAddr = '0;
  logic [23:0] loadData = '0;
  logic [7:0]  keyA = '0, keyB = '0;
  logic        inValidA = 1'b0, inValidB = 1'b0;
  logic        outValidA, outValidB;
  logic [3:0]  rangeA, rangeB;
  logic [15:0] tuplesA, tuplesB;

  int    nTests = 0, nFail = 0;
  bit    done = 0;
  string curTag = "R1";
  int    ep [15];
  logic [19:0] resM [16];
  exp_t  qA[$], qB[$];

  always #(CLK_P/2) clk = ~clk;

  qt_range_search u0 (
    .clk(clk), .rst_n(rst_n), .loadEn(loadEn), .loadSel(loadSel), .loadAddr(loadAddr),
    .loadData(loadData), .keyA(keyA), .inValidA(inValidA), .keyB(keyB), .inValidB(inValidB),
    .outValidA(outValidA), .rangeA(rangeA), .tuplesA(tuplesA),
    .outValidB(outValidB), .rangeB(rangeB), .tuplesB(tuplesB)
  );

  function automatic exp_t model(bit v, logic [7:0] k);
    exp_t e;
    int cnt = 0;
    for (int i = 0; i < 15; i++) if (ep[i] < int'(k)) cnt++;
    e.v = v;
    e.rid = resM[cnt][3:0];
    e.tup = resM[cnt][19:4];
    e.tag = curTag;
    return e;
  endfunction

  task automatic check(string port, exp_t e, logic gv, logic [3:0] gr, logic [15:0] gt);
    nTests++;
    if (gv !== e.v) begin
      nFail++;
      $display("FAIL %s port %s valid: got %0d exp %0d", e.tag, port, gv, e.v);
    end else if (e.v) begin
      nTests++;
      if (gr !== e.rid || gt !== e.tup) begin
        nFail++;
        $display("FAIL %s port %s result: got %h/%h exp %h/%h", e.tag, port, gr, gt, e.rid, e.tup);
      end
    end
  endtask

  // one cycle: compare at negedge, then drive and queue expectations
  task automatic step(bit vA, logic [7:0] kA, bit vB, logic [7:0] kB,
                      bit lEn = 0, logic [1:0] lSel = 0, logic [3:0] lAddr = 0,
                      logic [23:0] lData = 0);
    @(negedge clk);
    if (qA.size() == LAT) begin
      check("A", qA.pop_front(), outValidA, rangeA, tuplesA);
      check("B", qB.pop_front(), outValidB, rangeB, tuplesB);
    end
    inValidA = vA; keyA = kA; inValidB = vB; keyB = kB;
    loadEn = lEn; loadSel = lSel; loadAddr = lAddr; loadData = lData;
    qA.push_back(model(vA, kA));
    qB.push_back(model(vB, kB));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic loadTree();
    idle(LAT);
    step(0, 0, 0, 0, 1, 2'd0, 4'd0, {ep[11][7:0], ep[7][7:0], ep[3][7:0]});
    for (int j = 0; j < 4; j++)
      step(0, 0, 0, 0, 1, 2'd1, 4'(j), {ep[4*j+2][7:0], ep[4*j+1][7:0], ep[4*j][7:0]});
    idle(1);
  endtask

  task automatic loadRes(int i, logic [19:0] val);
    resM[i] = val;
    step(0, 0, 0, 0, 1, 2'd2, 4'(i), {4'd0, val});
  endtask

  initial begin
    for (int i = 0; i < 15; i++) ep[i] = 255;
    for (int i = 0; i < 16; i++) resM[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < LAT; i++) begin
      exp_t z;
      z = model(0, 0);
      qA.push_back(z);
      qB.push_back(z);
    end
    // R1: cleared tree and table
    curTag = "R1";
    step(1, 8'h80, 1, 8'h05);
    step(1, 8'hff, 1, 8'h00);
    idle(LAT);

    // R8: load full 16-range tree and result table
    curTag = "R8";
    for (int i = 0; i < 15; i++) ep[i] = 10 + 15 * i;
    loadTree();
    for (int i = 0; i < 16; i++)
      loadRes(i, {2'((i+1)%4), 6'(i+40), 2'(i%4), 6'(i*3), 4'(15-i)});
    idle(1);
    step(1, 8'd100, 1, 8'd101);

    // R2 R5 R6: back-to-back sweep, independent keys on the two ports
    curTag = "R2";
    for (int k = 0; k < 256; k++) step(1, 8'(k), 1, 8'(255-k));
    curTag = "R6";
    for (int k = 0; k < 40; k++) step(1, 8'(k*7), 1, 8'(k*7));
    curTag = "R5";
    for (int k = 0; k < 30; k++) step(1, 8'(ep[k%15]), 1, 8'(ep[k%15]+1));

    // R7: bubbles mixed in
    curTag = "R7";
    for (int k = 0; k < 40; k++) step(k % 3 == 0, 8'(k*13), k % 2 == 0, 8'(k*5));

    // R4: isolated lookup
    curTag = "R4";
    idle(LAT);
    step(1, 8'd55, 0, 8'd0);
    idle(LAT);

    // R3: partial tree padded with all-ones
    curTag = "R3";
    for (int i = 0; i < 15; i++) ep[i] = 255;
    ep[0] = 20; ep[1] = 50; ep[2] = 90; ep[3] = 120; ep[4] = 200;
    loadTree();
    for (int k = 0; k < 256; k++) step(1, 8'(k), 1, 8'(255-k));

    // R8: rewrite one result entry and one node
    curTag = "R8";
    idle(LAT);
    loadRes(5, 20'hABCD5);
    idle(1);
    step(1, 8'd210, 1, 8'd255);
    ep[4] = 230;
    loadTree();
    step(1, 8'd210, 1, 8'd231);
    idle(LAT + 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule